// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block collects interrupt requests for a system of up to four processors and gives each processor a 4-bit priority level: the highest request that is pending, enabled and aimed at that processor. Each processor owns a small register bank. Software and other processors post soft and inter-processor requests there, and the owning processor retires them. A shared system bank holds the device-interrupt enable mask and the number of the one processor that receives every undirected device interrupt.

Device lines are level-sensitive and are not latched: the system pending view follows the inputs directly. Pending bits and mask bits change only through separate write-one-to-set and write-one-to-clear addresses, so several agents can update different bits without a read-modify-write. A set mask bit blocks its source. Software reaches the registers over a simple single-cycle bus with address, write enable, write data and registered read data.

Top module: `smp_irq_ctrl`

## Requirements
- R1: After synchronous reset every level output is 0, every per-CPU pending register reads 0, the system mask reads 32'hFFFFFFFF and the target register reads 0.
- R2: Bank n (address 0x1000*n, n < NCPU) sets a pending bit when 1 is written to that bit at offset 0x8. Bits written as 0 are unchanged. Pending reads back at offset 0x0.
- R3: A per-CPU bank clears a pending bit when 1 is written to that bit at offset 0x4. Bits written as 0 are unchanged.
- R4: The write-only addresses read back as 0. These are the per-CPU offsets 0x4 and 0x8 and the system-bank offsets 0x8 and 0xC.
- R5: In the system bank (address 0x4000), writing 1 to a bit at offset 0xC sets that mask bit and disables the source. Writing 1 at offset 0x8 clears the mask bit. The mask reads back at offset 0x4.
- R6: System-bank offset 0x0 returns the device input lines as they are on the cycle the read is presented. Read data appears one clock after the address.
- R7: The target register at system offset 0x10 is read/write and holds a 2-bit CPU index. Only the CPU with that index sees unmasked device sources.
- R8: Per-CPU pending bit k (1..15) carries level k. Bit 30 carries level 14 and bit 31 carries level 15. All other bits carry level 0.
- R9: Device bit 31 (the memory-error source) carries level 15. Every other device bit i carries level (i mod 15)+1.
- R10: Each CPU's output is the highest level among its pending bits and, if it is the target, the unmasked device bits. It is 0 when none qualify. It is registered, so it is valid one clock after the state or inputs that produce it.
- R11: An access to bank field addr[15:12] that is neither a present CPU bank nor bank 4 is ignored and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | 32 | Level-sensitive device interrupt lines |
| addr | input | 16 | Register byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one clock after the address |
| cpu_lvl | output | 4*NCPU | Priority level per CPU, CPU n at bits [4n+3:4n] |

## Verification
The hardest case is a device request that the mask has unblocked while the target is a different CPU. The device level must then reach exactly one output and be merged with that CPU's own soft requests. A vector table reprograms every pending, mask and target register from scratch for each row. Each row then checks all four outputs together, covering masked sources, mixed soft and device levels, unmapped bits and a change of target. Directed tests follow for partial set/clear patterns, write-only readback and stray bank addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 4;
  localparam int REG_W = 32;

  function automatic logic [LVL_W-1:0] cpu_bit_lvl(input int i);
    if (i >= 1 && i <= 15) return LVL_W'(i);
    if (i == 30) return LVL_W'(14);
    if (i == 31) return LVL_W'(15);
    return '0;
  endfunction

  function automatic logic [LVL_W-1:0] dev_bit_lvl(input int i);
    if (i == 31) return LVL_W'(15);
    return LVL_W'((i % 15) + 1);
  endfunction

  function automatic logic [LVL_W-1:0] cpu_max(input logic [REG_W-1:0] v);
    logic [LVL_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (v[i] && cpu_bit_lvl(i) > m) m = cpu_bit_lvl(i);
    return m;
  endfunction

  function automatic logic [LVL_W-1:0] dev_max(input logic [REG_W-1:0] v);
    logic [LVL_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (v[i] && dev_bit_lvl(i) > m) m = dev_bit_lvl(i);
    return m;
  endfunction
endpackage

// File: rtl/irqc_cpu_bank.sv
module irqc_cpu_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_clr,
  input  logic          wr_set,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst)         pend <= '0;
    else if (wr_set) pend <= pend | wdata;
    else if (wr_clr) pend <= pend & ~wdata;
  end

  // R2
  set_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (pend & $past(wdata)) == $past(wdata));
  // R2
  set_zeros_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (pend & ~$past(wdata)) == ($past(pend) & ~$past(wdata)));
  // R3
  clr_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (pend & $past(wdata)) == '0);
endmodule

// File: rtl/irqc_glb_bank.sv
module irqc_glb_bank #(
  parameter int DW    = 32,
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mclr,
  input  logic             wr_mset,
  input  logic             wr_tgt,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    mask,
  output logic [TGT_W-1:0] tgt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      tgt  <= '0;
    end else begin
      if (wr_mset)      mask <= mask | wdata;
      else if (wr_mclr) mask <= mask & ~wdata;
      if (wr_tgt)       tgt  <= wdata[TGT_W-1:0];
    end
  end

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mset |=> (mask & $past(wdata)) == $past(wdata));
  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mclr |=> (mask & $past(wdata)) == '0);
  // R7
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_tgt |=> tgt == $past(tgt));
endmodule

// File: rtl/irqc_lvl_sel.sv
module irqc_lvl_sel
  import irqc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    pend_cpu,
  input  logic [DW-1:0]    dev_act,
  input  logic             is_tgt,
  output logic [LVL_W-1:0] lvl
);
  logic [LVL_W-1:0] own_l, dev_l, nxt;

  always_comb begin
    own_l = cpu_max(pend_cpu);
    dev_l = is_tgt ? dev_max(dev_act) : '0;
    nxt   = (dev_l > own_l) ? dev_l : own_l;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= nxt;
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_cpu == '0 && (!is_tgt || dev_act == '0)) |=> lvl == '0);
  // R8
  top_ipi_chk: assert property (@(posedge clk) disable iff (rst)
    pend_cpu[31] |=> lvl == LVL_W'(15));
  // R9
  mem_err_chk: assert property (@(posedge clk) disable iff (rst)
    (is_tgt && dev_act[31]) |=> lvl == LVL_W'(15));
endmodule

// File: rtl/smp_irq_ctrl.sv
module smp_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32,
  parameter int AW   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DW-1:0]         dev_irq,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         rd_data,
  output logic [NCPU*LVL_W-1:0] cpu_lvl
);
  localparam int MAX_CPU  = 4;
  localparam int TGT_W    = 2;
  localparam int BANK_W   = AW - 12;
  localparam int GLB_BANK = MAX_CPU;
  localparam logic [11:0] OFF_PEND = 12'h000;
  localparam logic [11:0] OFF_CLR  = 12'h004;
  localparam logic [11:0] OFF_SET  = 12'h008;
  localparam logic [11:0] OFF_MASK = 12'h004;
  localparam logic [11:0] OFF_MCLR = 12'h008;
  localparam logic [11:0] OFF_MSET = 12'h00C;
  localparam logic [11:0] OFF_TGT  = 12'h010;

  logic [BANK_W-1:0] bank;
  logic [11:0]       off;
  logic              glb_hit;
  logic [DW-1:0]     pend [NCPU];
  logic [DW-1:0]     mask, dev_act, rd_nxt;
  logic [TGT_W-1:0]  tgt;

  assign bank    = addr[AW-1:12];
  assign off     = addr[11:0];
  assign glb_hit = (bank == BANK_W'(GLB_BANK));
  assign dev_act = dev_irq & ~mask;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit;
    assign hit = (bank == BANK_W'(c));

    irqc_cpu_bank #(.DW(DW)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_clr (wr_en && hit && off == OFF_CLR),
      .wr_set (wr_en && hit && off == OFF_SET),
      .wdata  (wr_data),
      .pend   (pend[c])
    );

    irqc_lvl_sel #(.DW(DW)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .pend_cpu (pend[c]),
      .dev_act  (dev_act),
      .is_tgt   (tgt == TGT_W'(c)),
      .lvl      (cpu_lvl[c*LVL_W +: LVL_W])
    );
  end

  irqc_glb_bank #(.DW(DW), .TGT_W(TGT_W)) u_glb (
    .clk     (clk),
    .rst     (rst),
    .wr_mclr (wr_en && glb_hit && off == OFF_MCLR),
    .wr_mset (wr_en && glb_hit && off == OFF_MSET),
    .wr_tgt  (wr_en && glb_hit && off == OFF_TGT),
    .wdata   (wr_data),
    .mask    (mask),
    .tgt     (tgt)
  );

  always_comb begin
    rd_nxt = '0;
    for (int c = 0; c < NCPU; c++)
      if (bank == BANK_W'(c) && off == OFF_PEND) rd_nxt = pend[c];
    if (glb_hit) begin
      case (off)
        OFF_PEND: rd_nxt = dev_irq;
        OFF_MASK: rd_nxt = mask;
        OFF_TGT:  rd_nxt = DW'(tgt);
        default:  rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R4
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (off == OFF_SET || (glb_hit && off == OFF_MSET)) |=> rd_data == '0);
  // R11
  stray_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (bank >= BANK_W'(NCPU) && !glb_hit) |=> rd_data == '0);
endmodule

// File: tb/smp_irq_ctrl_tb.sv
module smp_irq_ctrl_tb;
  localparam int NCPU = 4;
  localparam int VW   = 114;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] dev_irq = '0;
  logic [15:0] addr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] cpu_lvl;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  smp_irq_ctrl #(.NCPU(NCPU), .DW(32), .AW(16)) u_dut (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_lvl(cpu_lvl)
  );

  // {cpu0 pending, dev_irq, mask, target, expected levels {l3,l2,l1,l0}}
  localparam logic [VW-1:0] VEC [9] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 2'd0, 16'h0000},
    {32'h0000_0020, 32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 16'h0005},
    {32'h4000_0008, 32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 16'h000E},
    {32'h0000_0000, 32'h0000_0004, 32'h0000_0000, 2'd2, 16'h0300},
    {32'h0000_0000, 32'h0000_0004, 32'h0000_0004, 2'd2, 16'h0000},
    {32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 2'd3, 16'hF00F},
    {32'h0001_0000, 32'h0010_0000, 32'h0000_0000, 2'd1, 16'h0060},
    {32'h0000_0200, 32'h0000_2000, 32'h0000_0000, 2'd0, 16'h000E},
    {32'h0000_0004, 32'h0000_4000, 32'h0000_0000, 2'd1, 16'h00F2}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = 16'h7000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 0;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 levels", 32'(cpu_lvl), 32'h0);
    rd(16'h4004, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd(16'h4010, r); chk("R1 target", r, 32'h0);
    rd(16'h0000, r); chk("R1 pend0", r, 32'h0);
    rd(16'h3000, r); chk("R1 pend3", r, 32'h0);

    // table walk (R7 R8 R9 R10)
    for (int v = 0; v < 9; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      wr(16'h0004, 32'hFFFF_FFFF);
      wr(16'h0008, e[113:82]);
      wr(16'h400C, 32'hFFFF_FFFF);
      wr(16'h4008, ~e[49:18]);
      wr(16'h4010, 32'(e[17:16]));
      dev_irq = e[81:50];
      settle(); settle();
      chk($sformatf("R10 vector %0d", v), 32'(cpu_lvl), 32'(e[15:0]));
    end
    wr(16'h0004, 32'hFFFF_FFFF);
    dev_irq = '0;
    wr(16'h400C, 32'hFFFF_FFFF);
    wr(16'h4010, 32'd0);

    // R2 write-one-to-set, zeros no effect
    wr(16'h1008, 32'h0000_00F0);
    wr(16'h1008, 32'h0000_0003);
    rd(16'h1000, r); chk("R2 set merge", r, 32'h0000_00F3);
    chk("R8 cpu1 level", 32'(cpu_lvl[7:4]), 32'd7);
    // R3 write-one-to-clear
    wr(16'h1004, 32'h0000_0030);
    rd(16'h1000, r); chk("R3 clear partial", r, 32'h0000_00C3);
    // R4 write-only readback
    rd(16'h1004, r); chk("R4 cpu clr read", r, 32'h0);
    rd(16'h1008, r); chk("R4 cpu set read", r, 32'h0);
    rd(16'h4008, r); chk("R4 mask_clr read", r, 32'h0);
    rd(16'h400C, r); chk("R4 mask_set read", r, 32'h0);
    // R5 mask set/clear readback
    wr(16'h4008, 32'h8000_00FF);
    wr(16'h400C, 32'h0000_000F);
    rd(16'h4004, r); chk("R5 mask", r, 32'h7FFF_FF0F);
    // R9 memory-error source level once unmasked, target 0
    dev_irq = 32'h8000_0000;
    settle(); settle();
    chk("R9 mem err level", 32'(cpu_lvl[3:0]), 32'd15);
    wr(16'h400C, 32'h8000_0000);
    settle();
    chk("R5 masked mem err", 32'(cpu_lvl[3:0]), 32'd0);
    // R6 live device view
    dev_irq = 32'hA5A5_0001;
    rd(16'h4000, r); chk("R6 dev pending", r, 32'hA5A5_0001);
    dev_irq = 32'h0;
    // R7 target readback
    wr(16'h4010, 32'h0000_0003);
    rd(16'h4010, r); chk("R7 target", r, 32'h3);
    // R11 stray banks ignored
    wr(16'h5008, 32'hFFFF_FFFF);
    wr(16'hF008, 32'hFFFF_FFFF);
    rd(16'h5000, r); chk("R11 stray read", r, 32'h0);
    rd(16'h2000, r); chk("R11 cpu2 untouched", r, 32'h0);
    rd(16'h3000, r); chk("R11 cpu3 untouched", r, 32'h0);
    chk("R11 levels", 32'(cpu_lvl[15:8]), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule